// File: doc/BRIEF.md
# System-Control Register File with Masked Writes

This block holds the processor's system-control registers and exposes them through a single access port. Registers are addressed by a 5-bit register number and a 3-bit select. A move-to access writes one register and a move-from access reads one. Every register has its own pair of masks. One mask marks the bits a write replaces, the other marks the bits that survive a write. Any bit covered by neither mask is cleared by a write.

Two registers have side effects. A write to the translation entry-high register that changes its 8-bit address-space ID sends a one-cycle flush pulse to the translation cache. A write to the status register re-evaluates the interrupt request. The request rises when interrupts become enabled and a pending interrupt is unmasked. It falls when interrupts become disabled. The timer, the random-index generator and exception entry sit outside this block.

The read data, the invalid flag and the flush pulse are registered and appear one clock after the access. The asynchronous active-low reset is released synchronously inside the block, two clock edges after `rst_n` rises.

Top module: `sysctl_regfile`

## Requirements
- R1: An access with a nonzero select is invalid unless the register number is 16 or 28. An invalid write changes no register. An invalid read returns 0, and `bad_acc` is 1 in the cycle after the access.
- R2: An access to a register number that is not implemented returns 0 and sets `bad_acc` for one cycle. The implemented numbers are 0, 2–6, 10, 12–14, 16 and 17 with select 0, 16 with select 1, and 23. Register 28 is not implemented with any select.
- R3: A write to register 0 keeps bit 31 and replaces bits 3:0. All other bits become 0.
- R4: Writes to registers 2 and 3 are masked with 0x3FFFFFFF. Writes to register 5 are masked with 0x01FFE000. Writes to register 6 keep only bits 3:0.
- R5: A write to register 4 keeps bits 31:23, replaces bits 22:4 and clears bits 3:0.
- R6: A write to register 10 is masked with 0xFFFFE0FF. When bits 7:0 of the written data differ from the stored bits 7:0, `tlb_flush` is 1 for exactly the cycle after the write. Otherwise it stays 0.
- R7: A write to register 12 is masked with 0xFA78FF01. Bit 0 is the interrupt enable. Written bits 1 and 2 (exception level and error level) are not stored, but they take part in the interrupt evaluation of that same write.
- R8: A register-12 write raises `irq_req` in the next cycle when all of the following hold:
  - stored bit 0 was 0 and the new bit 0 is 1;
  - written bits 1 and 2 are 0;
  - debug mode is off;
  - (new status AND effective cause AND 0x0000FF00) is nonzero.
- R9: A register-12 write whose new bit 0 is 0 while stored bit 0 was 1 clears `irq_req`. Every other access leaves `irq_req` unchanged.
- R10: A write to register 13 keeps the bits under 0xB000F87C and writes only the bits under 0x00C00300. A read of register 13 returns the stored value with `irq_pend` ORed into bits 15:8. This ORed value is the effective cause used by R8.
- R11: Register 17 stores all 32 written bits, and a read returns the stored value shifted right by 4. Register 14 stores and returns all 32 bits.
- R12: A write to register 23 keeps the bits under 0x8C03FC1F and writes the bits under 0x13300120. Written bit 30 sets or clears the debug-mode flag. A read of register 23 ORs that flag into bit 30.
- R13: After reset, all outputs and registers are 0, except register 16 select 0, which holds `CFG0_RST`.
  - A write to register 16 select 0 keeps the bits under 0xFE17FF80 and replaces bit 0.
  - Register 16 select 1 is read-only and returns `CFG1_VAL`.
  - `rd_data` loads in the cycle after `rd_en` and otherwise holds its value.
  - A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_en | input | 1 | Move-from (read) strobe |
| wr_en | input | 1 | Move-to (write) strobe |
| reg_num | input | 5 | Register number |
| sel | input | 3 | Register select |
| wr_data | input | 32 | Write data |
| irq_pend | input | 8 | Pending interrupt lines, shown in cause bits 15:8 |
| rd_data | output | 32 | Registered read data |
| bad_acc | output | 1 | One-cycle flag for an invalid or unimplemented access |
| tlb_flush | output | 1 | One-cycle flush pulse on an address-space ID change |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench first targets writes that rewrite the same address-space ID. A design that compared the whole entry-high word instead of the ID field would flush when the page number alone changes. The interrupt edge cases come next:
- enabling interrupts while the written exception bit is set;
- enabling them while debug mode is on;
- enabling them with no pending line;
- re-writing status with the enable already set.

A design that tested the level of the enable instead of its edge, or that used the stored exception bits, would raise or drop the request at the wrong write. Invalid selects on implemented numbers are written and then read back through select 0, which exposes a design that decodes only the register number. The shifted address read and the kept-bit masks expose designs that store or return unmasked data.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW     = 32;
  localparam int RN_W   = 5;
  localparam int SEL_W  = 3;
  localparam int NSLOT  = 14;
  localparam int SLOT_W = $clog2(NSLOT);

  typedef logic [DW-1:0] word_t;

  localparam int SL_IDX   = 0;
  localparam int SL_LO0   = 1;
  localparam int SL_LO1   = 2;
  localparam int SL_CTX   = 3;
  localparam int SL_PMASK = 4;
  localparam int SL_WIRED = 5;
  localparam int SL_EHI   = 6;
  localparam int SL_STAT  = 7;
  localparam int SL_CAUSE = 8;
  localparam int SL_EPC   = 9;
  localparam int SL_CFG0  = 10;
  localparam int SL_LLA   = 11;
  localparam int SL_DBG   = 12;
  localparam int SL_CFG1  = 13;

  localparam int    IE_BIT  = 0;
  localparam int    EXL_BIT = 1;
  localparam int    ERL_BIT = 2;
  localparam int    DM_BIT  = 30;
  localparam int    ASID_W  = 8;
  localparam int    IP_LSB  = 8;
  localparam word_t IP_MASK = 32'h0000FF00;

  typedef struct packed {
    logic              ok;
    logic [SLOT_W-1:0] slot;
  } dec_t;

  // bits that a write replaces
  function automatic word_t take_of(int s);
    case (s)
      SL_IDX:   return 32'h0000000F;
      SL_LO0:   return 32'h3FFFFFFF;
      SL_LO1:   return 32'h3FFFFFFF;
      SL_CTX:   return 32'h007FFFF0;
      SL_PMASK: return 32'h01FFE000;
      SL_WIRED: return 32'h0000000F;
      SL_EHI:   return 32'hFFFFE0FF;
      SL_STAT:  return 32'hFA78FF01;
      SL_CAUSE: return 32'h00C00300;
      SL_EPC:   return 32'hFFFFFFFF;
      SL_CFG0:  return 32'h00000001;
      SL_LLA:   return 32'hFFFFFFFF;
      SL_DBG:   return 32'h13300120;
      default:  return 32'h00000000;
    endcase
  endfunction

  // bits that survive a write
  function automatic word_t keep_of(int s);
    case (s)
      SL_IDX:   return 32'h80000000;
      SL_CTX:   return 32'hFF800000;
      SL_CAUSE: return 32'hB000F87C;
      SL_CFG0:  return 32'hFE17FF80;
      SL_DBG:   return 32'h8C03FC1F;
      SL_CFG1:  return 32'hFFFFFFFF;
      default:  return 32'h00000000;
    endcase
  endfunction

  function automatic dec_t decode(logic [RN_W-1:0] r, logic [SEL_W-1:0] s);
    dec_t d;
    d.ok   = 1'b1;
    d.slot = '0;
    if (s != '0) begin
      if (r == 5'd16 && s == 3'd1) d.slot = SLOT_W'(SL_CFG1);
      else                         d.ok   = 1'b0;
    end else begin
      case (r)
        5'd0:    d.slot = SLOT_W'(SL_IDX);
        5'd2:    d.slot = SLOT_W'(SL_LO0);
        5'd3:    d.slot = SLOT_W'(SL_LO1);
        5'd4:    d.slot = SLOT_W'(SL_CTX);
        5'd5:    d.slot = SLOT_W'(SL_PMASK);
        5'd6:    d.slot = SLOT_W'(SL_WIRED);
        5'd10:   d.slot = SLOT_W'(SL_EHI);
        5'd12:   d.slot = SLOT_W'(SL_STAT);
        5'd13:   d.slot = SLOT_W'(SL_CAUSE);
        5'd14:   d.slot = SLOT_W'(SL_EPC);
        5'd16:   d.slot = SLOT_W'(SL_CFG0);
        5'd17:   d.slot = SLOT_W'(SL_LLA);
        5'd23:   d.slot = SLOT_W'(SL_DBG);
        default: d.ok   = 1'b0;
      endcase
    end
    return d;
  endfunction
endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [RN_W-1:0]   reg_num,
  input  logic [SEL_W-1:0]  sel,
  output logic              hit_ok,
  output logic [SLOT_W-1:0] hit_slot
);
  dec_t d;

  always_comb begin
    d        = decode(reg_num, sel);
    hit_ok   = d.ok;
    hit_slot = d.slot;
  end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter word_t CFG0_RST = 32'h80008082,
  parameter word_t CFG1_VAL = 32'h1E190C8A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] slot,
  input  word_t             wdata,
  input  logic [7:0]        pend,
  input  logic              dm,
  output word_t             rdval,
  output word_t             ehi_q,
  output word_t             stat_q,
  output word_t             cause_eff
);
  word_t regs_q [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam word_t RV   = (g == SL_CFG0) ? CFG0_RST :
                             (g == SL_CFG1) ? CFG1_VAL : '0;
    localparam word_t KEEP = keep_of(g);
    localparam word_t TAKE = take_of(g);
    word_t q, nxt;
    logic  hit;

    always_comb begin
      hit = we && (slot == SLOT_W'(g));
      nxt = (q & KEEP) | (wdata & TAKE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= RV;
      else if (hit) q <= nxt;
    end

    assign regs_q[g] = q;
  end

  assign ehi_q     = regs_q[SL_EHI];
  assign stat_q    = regs_q[SL_STAT];
  assign cause_eff = regs_q[SL_CAUSE] | (word_t'(pend) << IP_LSB);

  always_comb begin
    rdval = '0;
    for (int i = 0; i < NSLOT; i++)
      if (slot == SLOT_W'(i)) rdval = regs_q[i];
    if (slot == SLOT_W'(SL_LLA))   rdval = regs_q[SL_LLA] >> 4;
    if (slot == SLOT_W'(SL_CAUSE)) rdval = cause_eff;
    if (slot == SLOT_W'(SL_DBG))   rdval = regs_q[SL_DBG] | (word_t'(dm) << DM_BIT);
  end
endmodule

// File: rtl/sysctl_side.sv
module sysctl_side
  import sysctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ehi,
  input  logic  wr_stat,
  input  logic  wr_dbg,
  input  word_t wdata,
  input  word_t ehi_q,
  input  word_t stat_q,
  input  word_t cause_eff,
  output logic  flush,
  output logic  irq,
  output logic  dm
);
  logic  flush_d, irq_d, dm_d, arm;
  word_t new_stat;

  always_comb begin
    flush_d  = wr_ehi && (ehi_q[ASID_W-1:0] != wdata[ASID_W-1:0]);
    dm_d     = wr_dbg ? wdata[DM_BIT] : dm;
    new_stat = wdata & take_of(SL_STAT);
    arm      = new_stat[IE_BIT] && !stat_q[IE_BIT] &&
               !wdata[EXL_BIT] && !wdata[ERL_BIT] && !dm &&
               ((new_stat & cause_eff & IP_MASK) != '0);
    irq_d    = irq;
    if (wr_stat) begin
      if (arm)                                        irq_d = 1'b1;
      else if (!new_stat[IE_BIT] && stat_q[IE_BIT])   irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush <= 1'b0;
      irq   <= 1'b0;
      dm    <= 1'b0;
    end else begin
      flush <= flush_d;
      irq   <= irq_d;
      dm    <= dm_d;
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [31:0] CFG0_RST = 32'h80008082,
  parameter logic [31:0] CFG1_VAL = 32'h1E190C8A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [RN_W-1:0]  reg_num,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [7:0]       irq_pend,
  output logic [DW-1:0]    rd_data,
  output logic             bad_acc,
  output logic             tlb_flush,
  output logic             irq_req
);
  logic [1:0]        rst_sync;
  logic              rst_ns;
  logic              hit_ok, we, dm;
  logic [SLOT_W-1:0] hit_slot;
  word_t             rdval, ehi_q, stat_q, cause_eff, rd_d;
  logic              bad_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ns = rst_sync[1];

  sysctl_decode u_dec (
    .reg_num (reg_num),
    .sel     (sel),
    .hit_ok  (hit_ok),
    .hit_slot(hit_slot)
  );

  assign we = wr_en && hit_ok;

  sysctl_bank #(.CFG0_RST(CFG0_RST), .CFG1_VAL(CFG1_VAL)) u_bank (
    .clk      (clk),
    .rst_n    (rst_ns),
    .we       (we),
    .slot     (hit_slot),
    .wdata    (wr_data),
    .pend     (irq_pend),
    .dm       (dm),
    .rdval    (rdval),
    .ehi_q    (ehi_q),
    .stat_q   (stat_q),
    .cause_eff(cause_eff)
  );

  sysctl_side u_side (
    .clk      (clk),
    .rst_n    (rst_ns),
    .wr_ehi   (we && hit_slot == SLOT_W'(SL_EHI)),
    .wr_stat  (we && hit_slot == SLOT_W'(SL_STAT)),
    .wr_dbg   (we && hit_slot == SLOT_W'(SL_DBG)),
    .wdata    (wr_data),
    .ehi_q    (ehi_q),
    .stat_q   (stat_q),
    .cause_eff(cause_eff),
    .flush    (tlb_flush),
    .irq      (irq_req),
    .dm       (dm)
  );

  always_comb begin
    rd_d  = hit_ok ? rdval : '0;
    bad_d = (rd_en || wr_en) && !hit_ok;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rd_data <= '0;
      bad_acc <= 1'b0;
    end else begin
      bad_acc <= bad_d;
      if (rd_en) rd_data <= rd_d;
    end
  end
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk (
  input logic        clk,
  input logic        rst_ns,
  input logic        rd_en,
  input logic        wr_en,
  input logic [4:0]  reg_num,
  input logic [2:0]  sel,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        bad_acc,
  input logic        tlb_flush,
  input logic        irq_req
);
  p_badsel_flag_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    ((rd_en || wr_en) && sel != 3'd0 && reg_num != 5'd16 && reg_num != 5'd28) |=> bad_acc);

  p_badsel_zero_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_en && sel != 3'd0 && reg_num != 5'd16 && reg_num != 5'd28) |=> (rd_data == 32'd0));

  p_bad_needs_access_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    bad_acc |-> $past(rd_en || wr_en));

  p_flush_source_r6: assert property (@(posedge clk) disable iff (!rst_ns)
    tlb_flush |-> $past(wr_en && reg_num == 5'd10 && sel == 3'd0));

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(irq_req) |-> $past(wr_en && reg_num == 5'd12 && sel == 3'd0 &&
                             wr_data[0] && !wr_data[1] && !wr_data[2]));

  p_irq_fall_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(irq_req) |-> $past(wr_en && reg_num == 5'd12 && sel == 3'd0 && !wr_data[0]));
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk      (clk),
  .rst_ns   (rst_ns),
  .rd_en    (rd_en),
  .wr_en    (wr_en),
  .reg_num  (reg_num),
  .sel      (sel),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .bad_acc  (bad_acc),
  .tlb_flush(tlb_flush),
  .irq_req  (irq_req)
);

// File: tb/test_sysctl_regfile.sv
module test_sysctl_regfile;
  localparam logic [31:0] C0 = 32'h80008082;
  localparam logic [31:0] C1 = 32'h1E190C8A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en, wr_en;
  logic [4:0]  reg_num;
  logic [2:0]  sel;
  logic [31:0] wr_data;
  logic [7:0]  irq_pend;
  logic [31:0] rd_data;
  logic        bad_acc, tlb_flush, irq_req;

  always #4 clk = ~clk;

  sysctl_regfile #(.CFG0_RST(C0), .CFG1_VAL(C1)) i_sysctl_regfile (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .reg_num(reg_num), .sel(sel), .wr_data(wr_data), .irq_pend(irq_pend),
    .rd_data(rd_data), .bad_acc(bad_acc), .tlb_flush(tlb_flush), .irq_req(irq_req)
  );

  int  vectors = 0, miscompares = 0;
  bit  done = 0;

  // behavioural reference state
  logic [31:0] m_idx, m_lo0, m_lo1, m_ctx, m_pm, m_wired, m_ehi, m_stat,
               m_cause, m_epc, m_cfg0, m_lla, m_dbg;
  logic        m_dm, m_irq;
  logic [31:0] e_rd;
  logic        e_bad, e_flush;

  function automatic bit m_valid(int r, int s);
    if (s != 0) return (r == 16 && s == 1);
    return (r inside {0, 2, 3, 4, 5, 6, 10, 12, 13, 14, 16, 17, 23});
  endfunction

  function automatic logic [31:0] m_read(int r, int s, logic [7:0] p);
    if (!m_valid(r, s)) return 32'd0;
    if (r == 16) return (s == 1) ? C1 : m_cfg0;
    case (r)
      0:  return m_idx;
      2:  return m_lo0;
      3:  return m_lo1;
      4:  return m_ctx;
      5:  return m_pm;
      6:  return m_wired;
      10: return m_ehi;
      12: return m_stat;
      13: return m_cause | {16'd0, p, 8'd0};
      14: return m_epc;
      17: return m_lla >> 4;
      default: return m_dbg | {1'b0, m_dm, 30'd0};
    endcase
  endfunction

  task automatic m_write(int r, int s, logic [31:0] d, logic [7:0] p);
    logic [31:0] ns;
    if (!m_valid(r, s)) return;
    case (r)
      0:  m_idx   = (m_idx & 32'h80000000) | (d & 32'h0000000F);
      2:  m_lo0   = d & 32'h3FFFFFFF;
      3:  m_lo1   = d & 32'h3FFFFFFF;
      4:  m_ctx   = (m_ctx & 32'hFF800000) | (d & 32'h007FFFF0);
      5:  m_pm    = d & 32'h01FFE000;
      6:  m_wired = d & 32'h0000000F;
      10: begin
        e_flush = (m_ehi[7:0] != d[7:0]);
        m_ehi   = d & 32'hFFFFE0FF;
      end
      12: begin
        ns = d & 32'hFA78FF01;
        if (ns[0] && !m_stat[0] && !d[1] && !d[2] && !m_dm &&
            ((ns & (m_cause | {16'd0, p, 8'd0}) & 32'h0000FF00) != 0))
          m_irq = 1'b1;
        else if (!ns[0] && m_stat[0])
          m_irq = 1'b0;
        m_stat = ns;
      end
      13: m_cause = (m_cause & 32'hB000F87C) | (d & 32'h00C00300);
      14: m_epc   = d;
      16: if (s == 0) m_cfg0 = (m_cfg0 & 32'hFE17FF80) | (d & 32'h00000001);
      17: m_lla   = d;
      23: begin
        m_dbg = (m_dbg & 32'h8C03FC1F) | (d & 32'h13300120);
        m_dm  = d[30];
      end
      default: ;
    endcase
  endtask

  task automatic compare(string tag);
    bit bad;
    vectors++;
    bad = 0;
    if (rd_data !== e_rd) begin
      $display("FAIL %s rd_data actual %08h expected %08h", tag, rd_data, e_rd); bad = 1;
    end
    if (bad_acc !== e_bad) begin
      $display("FAIL %s bad_acc actual %0b expected %0b", tag, bad_acc, e_bad); bad = 1;
    end
    if (tlb_flush !== e_flush) begin
      $display("FAIL %s tlb_flush actual %0b expected %0b", tag, tlb_flush, e_flush); bad = 1;
    end
    if (irq_req !== m_irq) begin
      $display("FAIL %s irq_req actual %0b expected %0b", tag, irq_req, m_irq); bad = 1;
    end
    if (bad) miscompares++;
  endtask

  // one access; called just after a falling edge
  task automatic step(bit rd, bit wr, int r, int s, logic [31:0] d,
                      logic [7:0] p, string tag);
    rd_en = rd; wr_en = wr; reg_num = 5'(r); sel = 3'(s);
    wr_data = d; irq_pend = p;
    @(posedge clk);
    e_bad   = (rd || wr) && !m_valid(r, s);
    e_flush = 1'b0;
    if (rd) e_rd = m_read(r, s, p);
    if (wr) m_write(r, s, d, p);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic wr(int r, int s, logic [31:0] d, logic [7:0] p, string tag);
    step(0, 1, r, s, d, p, tag);
  endtask
  task automatic rd(int r, int s, logic [7:0] p, string tag);
    step(1, 0, r, s, 32'd0, p, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL R13 watchdog actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst_n = 0; rd_en = 0; wr_en = 0; reg_num = 0; sel = 0; wr_data = 0; irq_pend = 0;
    m_idx = 0; m_lo0 = 0; m_lo1 = 0; m_ctx = 0; m_pm = 0; m_wired = 0; m_ehi = 0;
    m_stat = 0; m_cause = 0; m_epc = 0; m_cfg0 = C0; m_lla = 0; m_dbg = 0;
    m_dm = 0; m_irq = 0; e_rd = 0; e_bad = 0; e_flush = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    compare("R13 reset");
    // R2: sweep all numbers with select 0 after reset
    for (int r = 0; r < 32; r++) rd(r, 0, 8'h00, "R2 sweep");
    rd(28, 0, 8'h00, "R2 reg28");
    rd(16, 1, 8'h00, "R13 config1");
    wr(16, 1, 32'hFFFFFFFF, 8'h00, "R13 config1 ro");
    rd(16, 1, 8'h00, "R13 config1 ro");
    wr(16, 0, 32'hFFFFFFFF, 8'h00, "R13 config0");
    rd(16, 0, 8'h00, "R13 config0");
    // R3 .. R5
    wr(0, 0, 32'hFFFFFFFF, 8'h00, "R3"); rd(0, 0, 8'h00, "R3");
    wr(2, 0, 32'hFFFFFFFF, 8'h00, "R4"); rd(2, 0, 8'h00, "R4");
    wr(3, 0, 32'hC0000001, 8'h00, "R4"); rd(3, 0, 8'h00, "R4");
    wr(5, 0, 32'hFFFFFFFF, 8'h00, "R4"); rd(5, 0, 8'h00, "R4");
    wr(6, 0, 32'hFFFFFFF5, 8'h00, "R4"); rd(6, 0, 8'h00, "R4");
    wr(4, 0, 32'hFFFFFFFF, 8'h00, "R5"); rd(4, 0, 8'h00, "R5");
    // R1: invalid selects on implemented number 5
    wr(5, 1, 32'h00000000, 8'h00, "R1 write");
    rd(5, 0, 8'h00, "R1 unchanged");
    rd(5, 3, 8'h00, "R1 read zero");
    wr(28, 2, 32'h1, 8'h00, "R1 reg28 sel2");
    // R6 flush
    wr(10, 0, 32'h12345678, 8'h00, "R6 asid change");
    wr(10, 0, 32'hABCDE078, 8'h00, "R6 same asid");
    wr(10, 0, 32'hABCDE079, 8'h00, "R6 asid change again");
    rd(10, 0, 8'h00, "R6 mask");
    // R10 cause
    wr(13, 0, 32'hFFFFFFFF, 8'h00, "R10");
    rd(13, 0, 8'hA4, "R10 pend or");
    wr(13, 0, 32'h00000000, 8'h00, "R10 clear");
    // R7 R8 R9 status and interrupt
    wr(12, 0, 32'hFFFFFF06, 8'h00, "R7"); rd(12, 0, 8'h00, "R7");
    wr(12, 0, 32'h0000FF01, 8'h20, "R8 rise");
    wr(12, 0, 32'h0000FF01, 8'h00, "R9 ie held");
    wr(12, 0, 32'h0000FF00, 8'h20, "R9 fall");
    wr(12, 0, 32'h0000FF03, 8'h20, "R8 exl blocks");
    wr(12, 0, 32'h0000FF00, 8'h20, "R9");
    wr(12, 0, 32'h0000FF05, 8'h20, "R8 erl blocks");
    wr(12, 0, 32'h0000FF00, 8'h20, "R9");
    wr(12, 0, 32'h0000FF01, 8'h00, "R8 none pending");
    wr(12, 0, 32'h0000FF00, 8'h00, "R9");
    wr(12, 0, 32'h00000401, 8'h08, "R8 masked line");
    wr(12, 0, 32'h00000000, 8'h00, "R9");
    wr(13, 0, 32'h00000100, 8'h00, "R10 sw bit");
    wr(12, 0, 32'h00000101, 8'h00, "R8 sw pending");
    rd(7, 0, 8'h00, "R9 other access");
    wr(12, 0, 32'h00000000, 8'h00, "R9");
    // R12 debug mode
    wr(23, 0, 32'hFFFFFFFF, 8'h00, "R12");
    rd(23, 0, 8'h00, "R12 dm visible");
    wr(12, 0, 32'h0000FF01, 8'hFF, "R12 dm blocks");
    wr(12, 0, 32'h0000FF00, 8'hFF, "R9");
    wr(23, 0, 32'h00000000, 8'h00, "R12 dm clear");
    rd(23, 0, 8'h00, "R12");
    // R11
    wr(17, 0, 32'h12345678, 8'h00, "R11"); rd(17, 0, 8'h00, "R11 shift");
    wr(14, 0, 32'hDEADBEEF, 8'h00, "R11 epc"); rd(14, 0, 8'h00, "R11 epc");
    // R13: read and write in one cycle returns old value
    step(1, 1, 14, 0, 32'h01020304, 8'h00, "R13 read old");
    rd(14, 0, 8'h00, "R13");
    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int r, s, k;
      k = int'($urandom % 4);
      r = int'($urandom % 32);
      if (k == 0) r = 12;
      s = ($urandom % 5 == 0) ? int'($urandom % 8) : 0;
      step(bit'($urandom % 2), bit'($urandom % 2), r, s, $urandom,
           8'($urandom), "R13 mixed");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule